// File: doc/BRIEF.md
# Filtered Digital Lock Detector

This block decides whether a phase-locked loop is in lock from the phase-error width that a phase detector front end measures once per comparison cycle. Each measurement arrives as a count of fast sampling-clock periods on a valid/ready input. The filter has hysteresis. While unlocked, a measurement counts as good only if it is below a narrow entry window. Lock is declared after a run of consecutive good measurements. Once locked, the window widens to a hold window, and one measurement beyond it drops lock at once.

A select input picks what drives the single lock output pin. The choices are the filtered digital lock, a pump-activity indication, the feedback divider output, or the reference divider output. The remaining codes drive the pin low. Power-down clears the filter and forces the pin low. Both windows are input counts. With a 1 ns sampling clock, the usual settings are 15 and 30.

The measurement input never applies back-pressure. `meas_ready` is always high, and every cycle with `meas_valid` high hands over exactly one measurement.

Top module: `lock_flt_top`

## Requirements
- R1: `meas_ready` is high in every cycle, including during reset release and power-down, so that each cycle with `meas_valid` high transfers one measurement.
- R2: While unlocked, lock is reported (select 010) in the cycle after the edge that accepts the fifth consecutive measurement with `meas_err < win_enter`, and not after the fourth.
- R3: While unlocked, an accepted measurement with `meas_err >= win_enter` restarts the consecutive-good run from zero.
- R4: While locked, an accepted measurement with `meas_err <= win_hold` keeps lock asserted, even when it is at or above `win_enter`.
- R5: While locked, one accepted measurement with `meas_err > win_hold` clears lock at that edge, and a new run of five good measurements is then needed.
- R6: While `pwr_dn` is high, `ld_out` is low for every select code, and accepted measurements are ignored. Power-down clears lock and the run count.
- R7: A cycle without `meas_valid` leaves the lock state and the run count unchanged.
- R8: Select 000 gives the pump indication. `ld_out` is high in the cycle after a clock edge at which both `pump_up` and `pump_dn` were low, and low after an edge at which either was high.
- R9: Select 110 passes `n_div` to `ld_out`, and select 111 passes `r_div`, combinationally.
- R10: Select codes 001, 011, 100 and 101 drive `ld_out` low.
- R11: After reset the block is unlocked with a run count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| meas_valid | input | 1 | A phase-error measurement is present |
| meas_ready | output | 1 | Always high; the block accepts a measurement in every cycle |
| meas_err | input | ERR_W | Phase-error width in sampling-clock counts |
| win_enter | input | ERR_W | Entry window; measurements strictly below it count as good while unlocked |
| win_hold | input | ERR_W | Hold window; measurements above it drop lock |
| pwr_dn | input | 1 | Power-down; clears the filter and forces the output low |
| pump_up | input | 1 | Charge pump up activity |
| pump_dn | input | 1 | Charge pump down activity |
| n_div | input | 1 | Feedback divider output |
| r_div | input | 1 | Reference divider output |
| ld_sel | input | 3 | Output select code |
| ld_out | output | 1 | Selected lock or divider output |

## Verification
A wrong run count shows up in the digital mode. Lock rises one measurement early or late, or it survives a bad entry-window measurement that should have restarted the run. The error is visible in the cycle right after the fifth accepted measurement. A wrong lock state or a window compare on the wrong side shows one cycle after the deciding measurement. In that case lock survives an error above the hold window, or an error between the two windows drops it. Randomized runs compare the pin against a model in every cycle, so a slip in hysteresis is caught within a few measurements.

// File: rtl/lock_flt_pkg.sv
package lock_flt_pkg;
  // Output select codes; the numeric values are decoded by the output mux.
  localparam logic [2:0] SEL_PUMP  = 3'b000;
  localparam logic [2:0] SEL_DIGI  = 3'b010;
  localparam logic [2:0] SEL_NDIV  = 3'b110;
  localparam logic [2:0] SEL_RDIV  = 3'b111;
endpackage

// File: rtl/lock_flt_window.sv
module lock_flt_window #(
  parameter int ERR_W = 8
) (
  input  logic [ERR_W-1:0] err,
  input  logic [ERR_W-1:0] win_enter,
  input  logic [ERR_W-1:0] win_hold,
  input  logic             locked,
  output logic             in_window
);
  // Unlocked: strict compare against the narrow window.
  // Locked: an error equal to the wide window still passes.
  always_comb begin
    if (locked) in_window = (err <= win_hold);
    else        in_window = (err <  win_enter);
  end
endmodule

// File: rtl/lock_flt_filter.sv
module lock_flt_filter #(
  parameter int ERR_W    = 8,
  parameter int LOCK_RUN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_dn,
  input  logic             take,
  input  logic [ERR_W-1:0] err,
  input  logic [ERR_W-1:0] win_enter,
  input  logic [ERR_W-1:0] win_hold,
  output logic             locked
);
  localparam int CNT_W = $clog2(LOCK_RUN + 1);
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(LOCK_RUN - 1);
  localparam logic [CNT_W-1:0] RUN_MAX  = CNT_W'(LOCK_RUN);

  logic [CNT_W-1:0] run_q;
  logic             lock_q;
  logic             in_win;

  lock_flt_window #(.ERR_W(ERR_W)) win_i (
    .err       (err),
    .win_enter (win_enter),
    .win_hold  (win_hold),
    .locked    (lock_q),
    .in_window (in_win)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (pwr_dn) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (take) begin
      if (lock_q) begin
        if (!in_win) begin
          lock_q <= 1'b0;
          run_q  <= '0;
        end
      end else if (in_win) begin
        if (run_q >= RUN_LAST) begin
          lock_q <= 1'b1;
          run_q  <= RUN_MAX;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign locked = lock_q;

  // R2: lock only rises after a full run of good measurements
  a_r2_run_before_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> ($past(run_q) == RUN_LAST && $past(take) && !$past(pwr_dn)));
  // R5: an error past the hold window drops lock at once
  a_r5_drop_on_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && take && !pwr_dn && err > win_hold) |=> !lock_q);
  // R4: an error inside the hold window keeps lock
  a_r4_keep_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && take && !pwr_dn && err <= win_hold) |=> lock_q);
  // R7: no measurement, no change
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !pwr_dn) |=> ($stable(lock_q) && $stable(run_q)));
  // R6: power-down clears the filter
  a_r6_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!lock_q && run_q == '0));
  // R3: the run count never passes its saturation value
  a_r3_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_MAX);
endmodule

// File: rtl/lock_flt_pump.sv
module lock_flt_pump (
  input  logic clk,
  input  logic rst_n,
  input  logic pump_up,
  input  logic pump_dn,
  output logic quiet
);
  logic quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) quiet_q <= 1'b0;
    else        quiet_q <= !(pump_up || pump_dn);
  end

  assign quiet = quiet_q;

  // R8: the indication follows the pump activity of the previous edge
  a_r8_pump_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pump_up || pump_dn) |-> !quiet_q);
endmodule

// File: rtl/lock_flt_mux.sv
module lock_flt_mux
  import lock_flt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       pwr_dn,
  input  logic       dig_lock,
  input  logic       pump_quiet,
  input  logic       n_div,
  input  logic       r_div,
  output logic       out
);
  logic pick;

  always_comb begin
    case (sel)
      SEL_PUMP: pick = pump_quiet;
      SEL_DIGI: pick = dig_lock;
      SEL_NDIV: pick = n_div;
      SEL_RDIV: pick = r_div;
      default:  pick = 1'b0;
    endcase
  end

  assign out = pick && !pwr_dn;

  // R6: powered down means a low pin
  a_r6_pd_low: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> !out);
  // R10: reserved codes give a low pin
  a_r10_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'b001 || sel == 3'b011 || sel == 3'b100 || sel == 3'b101) |-> !out);
endmodule

// File: rtl/lock_flt_top.sv
module lock_flt_top #(
  parameter int ERR_W    = 8,
  parameter int LOCK_RUN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_valid,
  output logic             meas_ready,
  input  logic [ERR_W-1:0] meas_err,
  input  logic [ERR_W-1:0] win_enter,
  input  logic [ERR_W-1:0] win_hold,
  input  logic             pwr_dn,
  input  logic             pump_up,
  input  logic             pump_dn,
  input  logic             n_div,
  input  logic             r_div,
  input  logic [2:0]       ld_sel,
  output logic             ld_out
);
  logic take;
  logic dig_lock;
  logic pump_quiet;

  assign meas_ready = 1'b1;
  assign take       = meas_valid && meas_ready;

  lock_flt_filter #(.ERR_W(ERR_W), .LOCK_RUN(LOCK_RUN)) filt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_dn    (pwr_dn),
    .take      (take),
    .err       (meas_err),
    .win_enter (win_enter),
    .win_hold  (win_hold),
    .locked    (dig_lock)
  );

  lock_flt_pump pump_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .pump_up (pump_up),
    .pump_dn (pump_dn),
    .quiet   (pump_quiet)
  );

  lock_flt_mux mux_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (ld_sel),
    .pwr_dn     (pwr_dn),
    .dig_lock   (dig_lock),
    .pump_quiet (pump_quiet),
    .n_div      (n_div),
    .r_div      (r_div),
    .out        (ld_out)
  );
endmodule

// File: tb/lock_flt_top_tb_top.sv
module lock_flt_top_tb_top;
  localparam int ERR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic meas_valid = 1'b0;
  logic meas_ready;
  logic [ERR_W-1:0] meas_err = '0;
  logic [ERR_W-1:0] win_enter = 8'd15;
  logic [ERR_W-1:0] win_hold = 8'd30;
  logic pwr_dn = 1'b0, pump_up = 1'b0, pump_dn = 1'b0, n_div = 1'b0, r_div = 1'b0;
  logic [2:0] ld_sel = 3'b010;
  logic ld_out;

  int checks = 0;
  int errors = 0;
  int m_run = 0;
  bit m_lock = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lock_flt_top #(.ERR_W(ERR_W), .LOCK_RUN(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_ready(meas_ready),
    .meas_err(meas_err), .win_enter(win_enter), .win_hold(win_hold),
    .pwr_dn(pwr_dn), .pump_up(pump_up), .pump_dn(pump_dn),
    .n_div(n_div), .r_div(r_div), .ld_sel(ld_sel), .ld_out(ld_out)
  );

  function automatic bit exp_good(bit lk, int e, int en, int ho);
    return lk ? (e <= ho) : (e < en);
  endfunction

  task automatic check(bit act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ld_out=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Model update for one accepted edge.
  task automatic model_step(bit v, int e);
    if (pwr_dn) begin
      m_run = 0; m_lock = 1'b0;
    end else if (v) begin
      if (exp_good(m_lock, e, win_enter, win_hold)) begin
        if (!m_lock) begin
          m_run++;
          if (m_run >= 5) begin m_run = 5; m_lock = 1'b1; end
        end
      end else begin
        m_run = 0; m_lock = 1'b0;
      end
    end
  endtask

  // Drive at negedge, clock once, check at next negedge.
  task automatic cyc(bit v, int e, string tag);
    meas_valid = v;
    meas_err = ERR_W'(e);
    @(posedge clk);
    model_step(v, e);
    @(negedge clk);
    if (ld_sel == 3'b010) check(ld_out, m_lock && !pwr_dn, tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: ld_out=%0b expected=done", ld_out);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R11 reset state
    check(ld_out, 1'b0, "R11 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(meas_ready, 1'b1, "R1 ready");
    // R2: four good not enough, fifth locks
    for (int i = 0; i < 4; i++) cyc(1, 14, "R2 no early lock");
    cyc(1, 0, "R2 fifth locks");
    // R4: between windows keeps lock, 30 exactly keeps
    cyc(1, 22, "R4 keep mid");
    cyc(1, 30, "R4 keep edge");
    // R7: idle keeps
    cyc(0, 200, "R7 idle");
    // R5: above hold drops
    cyc(1, 31, "R5 drop");
    for (int i = 0; i < 4; i++) cyc(1, 3, "R5 relock run");
    cyc(1, 3, "R5 relocked");
    // R3: bad entry restarts
    cyc(1, 200, "R5 drop2");
    for (int i = 0; i < 3; i++) cyc(1, 2, "R3 run");
    cyc(1, 15, "R3 restart");
    for (int i = 0; i < 4; i++) cyc(1, 2, "R3 after restart");
    cyc(1, 2, "R3 lock after restart");
    // R7: idle in middle of run
    cyc(1, 90, "R5 drop3");
    cyc(1, 1, "R7 run1");
    cyc(1, 1, "R7 run2");
    cyc(0, 99, "R7 gap");
    cyc(1, 1, "R7 run3");
    cyc(1, 1, "R7 run4");
    cyc(1, 1, "R7 run5 locks");
    // R6: power-down
    pwr_dn = 1'b1;
    cyc(1, 0, "R6 pd low");
    for (int s = 0; s < 8; s++) begin
      ld_sel = 3'(s); n_div = 1'b1; r_div = 1'b1; #1;
      check(ld_out, 1'b0, "R6 pd any select");
    end
    ld_sel = 3'b010; n_div = 1'b0; r_div = 1'b0;
    pwr_dn = 1'b0;
    cyc(1, 0, "R6 cleared after pd");
    // R1 under power-down
    pwr_dn = 1'b1; #1; check(meas_ready, 1'b1, "R1 ready in pd"); pwr_dn = 1'b0;
    cyc(0, 0, "R6 pd clears");
    // R8 pump indication
    ld_sel = 3'b000;
    pump_up = 1'b1; @(negedge clk); check(ld_out, 1'b0, "R8 up active");
    pump_up = 1'b0; @(negedge clk); check(ld_out, 1'b1, "R8 quiet");
    pump_dn = 1'b1; @(negedge clk); check(ld_out, 1'b0, "R8 dn active");
    pump_dn = 1'b0; @(negedge clk); check(ld_out, 1'b1, "R8 quiet again");
    // R9 divider passthrough
    ld_sel = 3'b110; n_div = 1'b1; r_div = 1'b0; #1; check(ld_out, 1'b1, "R9 n high");
    n_div = 1'b0; r_div = 1'b1; #1; check(ld_out, 1'b0, "R9 n low");
    ld_sel = 3'b111; #1; check(ld_out, 1'b1, "R9 r high");
    r_div = 1'b0; #1; check(ld_out, 1'b0, "R9 r low");
    // R10 reserved codes
    n_div = 1'b1; r_div = 1'b1;
    foreach (ld_sel[i]) ;
    ld_sel = 3'b001; #1; check(ld_out, 1'b0, "R10 code 001");
    ld_sel = 3'b011; #1; check(ld_out, 1'b0, "R10 code 011");
    ld_sel = 3'b100; #1; check(ld_out, 1'b0, "R10 code 100");
    ld_sel = 3'b101; #1; check(ld_out, 1'b0, "R10 code 101");
    n_div = 1'b0; r_div = 1'b0;
    ld_sel = 3'b010;
    @(negedge clk);
    // Random phase, R2 R3 R4 R5 R6 R7 against the model
    for (int i = 0; i < 600; i++) begin
      int e;
      bit v;
      v = ($urandom_range(0, 3) != 0);
      e = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, 60)) : int'($urandom_range(0, 20));
      pwr_dn = ($urandom_range(0, 59) == 0);
      cyc(v, e, "R2-5 random");
    end
    pwr_dn = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule